// File: doc/BRIEF.md
# Barrel shift and rotate unit

A purely combinational 32-bit shifter for the execute stage of an integer core. It takes a data operand and produces, in the same cycle, the operand shifted right logically, shifted right arithmetically, shifted left, rotated right or rotated left. The shift distance comes either from the low five bits of a register operand or from a 5-bit immediate field. For rotate right, the distance always comes from the register operand.

All five operations share one logarithmic network. The network has five multiplexer stages, and each stage moves the data by a power of two. The network only ever moves bits toward bit 0:

- Left shifts reverse the bit order of the operand before the network and reverse it again afterwards.
- Left rotates are turned into right rotates by the complementary distance.

Top module: `barrel_shifter`

## Requirements
- R1: With op_i = 0 (logical right), result_o is data_i moved right by n positions, and the n vacated high bits are 0.
- R2: With op_i = 1 (arithmetic right), result_o is data_i moved right by n positions, and the vacated high bits are copies of data_i[31].
- R3: With op_i = 2 (left shift), result_o is data_i moved left by n positions, and the n vacated low bits are 0.
- R4: With op_i = 3 (rotate right), bits move toward bit 0, and bits that leave bit 0 re-enter at bit 31.
- R5: With op_i = 4 (rotate left), bits move toward bit 31, and bits that leave bit 31 re-enter at bit 0.
- R6: When the distance is taken from the register, only amt_reg_i[4:0] is used. Bits 31:5 of amt_reg_i have no effect on result_o.
- R7: For op_i values 0, 1, 2 and 4, amt_from_imm_i = 1 selects amt_imm_i as the distance n, and amt_from_imm_i = 0 selects amt_reg_i[4:0].
- R8: With op_i = 3, amt_from_imm_i and amt_imm_i have no effect. The distance is always amt_reg_i[4:0].
- R9: A distance of zero returns data_i unchanged for all five operations.
- R10: op_i values 5, 6 and 7 drive result_o to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Operand to shift or rotate |
| amt_reg_i | input | 32 | Register operand; its low five bits give the distance |
| amt_imm_i | input | 5 | Immediate distance, unsigned |
| amt_from_imm_i | input | 1 | 1 selects the immediate distance, 0 selects the register distance |
| op_i | input | 3 | Operation code: 0 logical right, 1 arithmetic right, 2 left shift, 3 rotate right, 4 rotate left |
| result_o | output | 32 | Shifted or rotated operand |

## Verification
Two things happen in the same evaluation and can interfere:

- **Distance selection and network direction.** In one evaluation the distance is chosen (register or immediate), and for a left rotate it is complemented before it reaches the network.
- **Fill value and wrap-around.** In the last stages both the vacated-bit fill and the rotate wrap are active at once.

To provoke these, the bench applies each operation with both distance sources. It uses register values whose high bits are set and immediates that disagree with the register. It sweeps every distance from 0 to 31 over operands with bit 31 both set and clear. Each result is judged against a model in the bench that is built from plain shift operators and concatenation, not from the stage structure.

// File: rtl/barrel_shifter_pkg.sv
package barrel_shifter_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SRL = 3'd0,
    OP_SRA = 3'd1,
    OP_SLL = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4
  } shift_op_e;

  typedef struct packed {
    logic valid;
    logic rotate;
    logic reverse;
    logic arith;
    logic negate;
    logic force_reg;
  } shift_ctrl_t;
endpackage

// File: rtl/shift_ctrl_dec.sv
module shift_ctrl_dec
  import barrel_shifter_pkg::*;
#(
  parameter int unsigned AMT_W = 5
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  input  logic [AMT_W-1:0] amt_imm_i,
  input  logic             amt_from_imm_i,
  output shift_ctrl_t      ctrl_o,
  output logic [AMT_W-1:0] net_amt_o
);
  logic [AMT_W-1:0] eff_amt;

  always_comb begin
    ctrl_o = '0;
    case (op_i)
      OP_SRL: ctrl_o.valid = 1'b1;
      OP_SRA: begin ctrl_o.valid = 1'b1; ctrl_o.arith = 1'b1; end
      OP_SLL: begin ctrl_o.valid = 1'b1; ctrl_o.reverse = 1'b1; end
      OP_ROR: begin ctrl_o.valid = 1'b1; ctrl_o.rotate = 1'b1; ctrl_o.force_reg = 1'b1; end
      OP_ROL: begin ctrl_o.valid = 1'b1; ctrl_o.rotate = 1'b1; ctrl_o.negate = 1'b1; end
      default: ctrl_o = '0;
    endcase
  end

  // rotate right has no immediate form
  assign eff_amt = (amt_from_imm_i && !ctrl_o.force_reg) ? amt_imm_i : amt_reg_i;

  // left rotate by n == right rotate by (2^AMT_W - n) mod 2^AMT_W
  assign net_amt_o = ctrl_o.negate ? (~eff_amt + 1'b1) : eff_amt;
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIST   = 1
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic              en_i,
  input  logic              rotate_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] moved;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i + DIST < DATA_W) begin : g_in
      assign moved[i] = din_i[i+DIST];
    end else begin : g_edge
      assign moved[i] = rotate_i ? din_i[i+DIST-DATA_W] : fill_i;
    end
  end

  assign dout_o = en_i ? moved : din_i;
endmodule

// File: rtl/bit_reverse.sv
module bit_reverse #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] flipped;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign flipped[i] = din_i[DATA_W-1-i];
  end

  assign dout_o = en_i ? flipped : din_i;
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [AMT_W-1:0]  amt_imm_i,
  input  logic              amt_from_imm_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned N_STAGE = AMT_W;

  shift_ctrl_t       ctrl;
  logic [AMT_W-1:0]  net_amt;
  logic [DATA_W-1:0] net_in;
  logic [DATA_W-1:0] net_out;
  logic [DATA_W-1:0] unrev_out;
  logic [DATA_W-1:0] stage_d [N_STAGE+1];
  logic              fill_bit;
  logic              amt_hi_unused;

  assign amt_hi_unused = ^amt_reg_i[DATA_W-1:AMT_W];

  shift_ctrl_dec #(.AMT_W(AMT_W)) u_dec (
    .op_i           (op_i),
    .amt_reg_i      (amt_reg_i[AMT_W-1:0]),
    .amt_imm_i      (amt_imm_i),
    .amt_from_imm_i (amt_from_imm_i),
    .ctrl_o         (ctrl),
    .net_amt_o      (net_amt)
  );

  bit_reverse #(.DATA_W(DATA_W)) u_rev_in (
    .en_i   (ctrl.reverse),
    .din_i  (data_i),
    .dout_o (net_in)
  );

  assign fill_bit   = ctrl.arith & data_i[DATA_W-1];
  assign stage_d[0] = net_in;

  for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
    shift_stage #(.DATA_W(DATA_W), .DIST(1 << k)) u_stage (
      .din_i    (stage_d[k]),
      .en_i     (net_amt[k]),
      .rotate_i (ctrl.rotate),
      .fill_i   (fill_bit),
      .dout_o   (stage_d[k+1])
    );
  end

  assign net_out = stage_d[N_STAGE];

  bit_reverse #(.DATA_W(DATA_W)) u_rev_out (
    .en_i   (ctrl.reverse),
    .din_i  (net_out),
    .dout_o (unrev_out)
  );

  assign result_o = ctrl.valid ? unrev_out : '0;
endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 5
) (
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] amt_reg_i,
  input logic [AMT_W-1:0]  amt_imm_i,
  input logic              amt_from_imm_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] result_o
);
  logic [AMT_W-1:0] n;
  int unsigned      ni;

  always_comb begin
    n  = (op_i == 3'd3 || !amt_from_imm_i) ? amt_reg_i[AMT_W-1:0] : amt_imm_i;
    ni = int'(n);
    if (op_i == 3'd0 && ni != 0)
      assert_srl_zero_fill_R1: assert ((result_o >> (DATA_W - ni)) == '0);
    if (op_i == 3'd1)
      assert_sra_sign_fill_R2: assert (result_o == DATA_W'($signed(data_i) >>> ni));
    if (op_i == 3'd2 && ni != 0)
      assert_sll_zero_fill_R3: assert ((result_o << (DATA_W - ni)) == '0);
    if (op_i == 3'd3 || op_i == 3'd4)
      assert_rot_keeps_ones_R4: assert ($countones(result_o) == $countones(data_i));
    if (op_i <= 3'd4 && ni == 0)
      assert_zero_amt_identity_R9: assert (result_o == data_i);
    if (op_i > 3'd4)
      assert_bad_op_zero_R10: assert (result_o == '0);
  end
endmodule

bind barrel_shifter barrel_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .data_i         (data_i),
  .amt_reg_i      (amt_reg_i),
  .amt_imm_i      (amt_imm_i),
  .amt_from_imm_i (amt_from_imm_i),
  .op_i           (op_i),
  .result_o       (result_o)
);

// File: tb/barrel_shifter_test.sv
`timescale 1ns/1ps
module barrel_shifter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic [4:0]  amt_imm_i = '0;
  logic        amt_from_imm_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] result_o;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  barrel_shifter uut (
    .data_i(data_i), .amt_reg_i(amt_reg_i), .amt_imm_i(amt_imm_i),
    .amt_from_imm_i(amt_from_imm_i), .op_i(op_i), .result_o(result_o)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] d,
                                        input logic [31:0] r, input logic [4:0] im,
                                        input logic sel);
    int n;
    logic [63:0] dd;
    n  = (op == 3'd3 || !sel) ? int'(r[4:0]) : int'(im);
    dd = {d, d};
    case (op)
      3'd0: return d >> n;
      3'd1: return $signed(d) >>> n;
      3'd2: return d << n;
      3'd3: return dd[n +: 32];
      3'd4: return dd[(32 - n) % 32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [31:0] d, input logic [31:0] r,
                       input logic [4:0] im, input logic sel);
    @(negedge clk);
    op_i = op; data_i = d; amt_reg_i = r; amt_imm_i = im; amt_from_imm_i = sel;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_run++;
    if (result_o !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d data=%h reg=%h imm=%0d sel=%0b got %h exp %h",
               req, op_i, data_i, amt_reg_i, amt_imm_i, amt_from_imm_i, result_o, exp);
    end
  endtask

  task automatic run_and_check(input string req, input logic [2:0] op, input logic [31:0] d,
                               input logic [31:0] r, input logic [4:0] im, input logic sel);
    apply(op, d, r, im, sel);
    check(req, model(op, d, r, im, sel));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("reset", 32'h0);
  endtask

  task automatic t_srl;      // R1
    run_and_check("R1", 3'd0, 32'hF000_000F, 32'd4, 5'd0, 1'b0);
    check("R1", 32'h0F00_0000);
    for (int s = 0; s < 32; s++) run_and_check("R1", 3'd0, 32'hDEAD_BEEF, s, 5'd0, 1'b0);
  endtask

  task automatic t_sra;      // R2
    run_and_check("R2", 3'd1, 32'h8000_0010, 32'd4, 5'd0, 1'b0);
    check("R2", 32'hF800_0001);
    run_and_check("R2", 3'd1, 32'h7000_0010, 32'd31, 5'd0, 1'b0);
    check("R2", 32'h0);
    for (int s = 0; s < 32; s++) run_and_check("R2", 3'd1, 32'h9ABC_DEF0, s, 5'd0, 1'b0);
  endtask

  task automatic t_sll;      // R3
    run_and_check("R3", 3'd2, 32'hF000_000F, 32'd4, 5'd0, 1'b0);
    check("R3", 32'h0000_00F0);
    for (int s = 0; s < 32; s++) run_and_check("R3", 3'd2, 32'h1234_5679, s, 5'd0, 1'b0);
  endtask

  task automatic t_ror;      // R4
    run_and_check("R4", 3'd3, 32'h0000_0001, 32'd1, 5'd0, 1'b0);
    check("R4", 32'h8000_0000);
    for (int s = 0; s < 32; s++) run_and_check("R4", 3'd3, 32'hC001_0F0A, s, 5'd0, 1'b0);
  endtask

  task automatic t_rol;      // R5, register and immediate forms
    run_and_check("R5", 3'd4, 32'h8000_0001, 32'd1, 5'd0, 1'b0);
    check("R5", 32'h0000_0003);
    run_and_check("R5", 3'd4, 32'h8000_0001, 32'd0, 5'd31, 1'b1);
    check("R5", 32'hC000_0000);
    for (int s = 0; s < 32; s++) run_and_check("R5", 3'd4, 32'h8765_4321, s, 5'd0, 1'b0);
  endtask

  task automatic t_reg_mask; // R6: high register bits ignored
    for (int op = 0; op < 5; op++) begin
      run_and_check("R6", 3'(op), 32'hA5A5_0F0F, 32'hFFFF_FFE3, 5'd0, 1'b0);
      check("R6", model(3'(op), 32'hA5A5_0F0F, 32'd3, 5'd0, 1'b0));
    end
  endtask

  task automatic t_imm_sel;  // R7
    for (int op = 0; op < 5; op++) begin
      if (op == 3) continue;
      run_and_check("R7", 3'(op), 32'h8421_F00D, 32'd9, 5'd17, 1'b1);
      run_and_check("R7", 3'(op), 32'h8421_F00D, 32'd9, 5'd17, 1'b0);
    end
    run_and_check("R7", 3'd0, 32'h8000_0000, 32'd0, 5'd31, 1'b1);
    check("R7", 32'h0000_0001);
  endtask

  task automatic t_ror_no_imm; // R8
    run_and_check("R8", 3'd3, 32'h0000_00F0, 32'd4, 5'd12, 1'b1);
    check("R8", 32'h0000_000F);
    run_and_check("R8", 3'd3, 32'h1357_9BDF, 32'd0, 5'd7, 1'b1);
    check("R8", 32'h1357_9BDF);
  endtask

  task automatic t_zero_amt; // R9
    for (int op = 0; op < 5; op++) begin
      apply(3'(op), 32'hCAFE_F00D, 32'hFFFF_FFE0, 5'd0, 1'b0);
      check("R9", 32'hCAFE_F00D);
      apply(3'(op), 32'hCAFE_F00D, 32'd5, 5'd0, 1'b1);
      check("R9", op == 3 ? model(3'd3, 32'hCAFE_F00D, 32'd5, 5'd0, 1'b1) : 32'hCAFE_F00D);
    end
  endtask

  task automatic t_bad_op;   // R10
    for (int op = 5; op < 8; op++) begin
      apply(3'(op), 32'hFFFF_FFFF, 32'd3, 5'd2, 1'b0);
      check("R10", 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_srl();
    t_sra();
    t_sll();
    t_ror();
    t_rol();
    t_reg_mask();
    t_imm_sel();
    t_ror_no_imm();
    t_zero_amt();
    t_bad_op();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule